// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol side of a 256-byte nonvolatile store that answers on a standard two-wire (I2C) bus. SCL and SDA arrive as raw pin samples and are synchronised to the system clock. The engine detects START and STOP conditions and matches the device address byte against a three-bit strap. It then carries out byte writes, page writes, and current-address, random and sequential reads. SDA is driven through an open-drain enable: when the enable is high, the line is pulled low.

Write data is collected in a one-page staging buffer. It reaches the array only when a STOP closes the transfer. That STOP also starts a self-timed write cycle. The cycle is a counter of system clocks, and while it runs the engine ignores the bus completely. A host can therefore poll with the device address until the byte is acknowledged again. A separate protection unit supplies the write-protect decision. When it is active, the write cycle still runs but the array is left unchanged.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A device address byte is accepted only if bits 7..4 are 1010 and bits 3..1 equal `dev_sel_i`. Bit 0 high selects read and bit 0 low selects write. On acceptance, SDA is driven low during the ninth clock. On a mismatch, SDA stays released and the engine waits for the next START.
- R2: In a write transfer, the word address byte and every data byte are acknowledged on their ninth clock.
- R3: The first byte after the word address lands at the word address. After each data byte, only address bits 3..0 advance, so bytes beyond the sixteenth wrap to the start of the same 16-byte page and overwrite earlier ones.
- R4: During a read, the address advances by one after every byte, and address FFh is followed by 00h.
- R5: The internal pointer holds the last accessed address plus one, after writes (page-wrapped) and after reads. A read that directly follows the device address starts at that pointer. A random read is a write header carrying the word address, then a repeated START and a read header.
- R6: Staged data is committed only at STOP. A START that arrives before the STOP discards it. A STOP that arrives before any data byte starts no write cycle, and the device keeps answering.
- R7: A STOP after one or more data bytes starts a write cycle of `WRITE_CYCLES` system clocks. During this cycle the engine never drives SDA, so its own address is not acknowledged. Once the cycle ends, the address is acknowledged again.
- R8: If `wp_i` is high at the closing STOP, the array keeps its old contents, but the write cycle still runs.
- R9: After each read byte, an acknowledge from the master (SDA low) makes the engine send the next byte. A no-acknowledge ends the read, and the bus is then released.
- R10: After reset, SDA is released. The SDA enable changes only in response to a detected SCL falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pin |
| sda_i | input | 1 | Raw SDA level from the pin (wired-AND bus) |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| dev_sel_i | input | 3 | Strapped device select compared with address bits 3..1 |
| wp_i | input | 1 | Write-protect decision from the protection unit; sampled at STOP |

## Verification
A wrong pointer or page-offset state is not visible when it occurs. It first shows on SDA as a wrong data byte, at the next current-address or sequential read, which may come many transfers later. The bench therefore reads back every write pattern and also issues reads that start from the pointer alone. A stuck or mis-sized write-cycle counter shows within one device address byte after STOP, as an acknowledge that is missing or comes too early. This is why a poll is made both immediately after STOP and again after the cycle ends. A phase error in the bit engine shows within one byte, as a shifted acknowledge or a corrupted data bit.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int OFS_W      = 4;
  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACKW, S_ACK, S_TX, S_MACK, S_IGN
  } eng_st_t;

  typedef enum logic [1:0] {K_DEV, K_WADR, K_WDAT} rx_kind_t;

  // header byte addresses this slave
  function automatic logic dev_hit(input logic [DATA_W-1:0] hdr, input logic [2:0] sel);
    return (hdr[7:4] == DEV_CODE) && (hdr[3:1] == sel);
  endfunction

  // write pointer: offset advances, page stays
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFS_W], a[OFS_W-1:0] + 1'b1};
  endfunction

  // read pointer: whole-array wrap
  function automatic logic [ADDR_W-1:0] lin_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/i2cee_bus_cond.sv
module i2cee_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s    = scl_sh[SYNC_STAGES-1];
  assign sda_s    = sda_sh[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cee_store.sv
module i2cee_store
  import i2cee_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_we,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              discard,
  input  logic              commit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pending
);
  logic [DATA_W-1:0]     mem  [DEPTH];
  logic [DATA_W-1:0]     pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [PAGE_W-1:0]     ppage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask <= '0;
      ppage <= '0;
    end else if (discard || commit) begin
      pmask <= '0;
    end else if (st_we) begin
      pmask[st_addr[OFS_W-1:0]] <= 1'b1;
      ppage <= st_addr[ADDR_W-1:OFS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (st_we) pbuf[st_addr[OFS_W-1:0]] <= st_data;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit && pmask[i]) mem[{ppage, OFS_W'(i)}] <= pbuf[i];
    end
  end

  assign rd_data = mem[rd_addr];
  assign pending = |pmask;
endmodule

// File: rtl/i2cee_wcycle.sv
module i2cee_wcycle #(
  parameter int CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (launch)     cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2cee_pkg::*;
#(
  parameter int WRITE_CYCLES = 50000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, live, launch, commit, discard, pending;
  logic wr_ev, rd_ev, ack_now;
  eng_st_t st;
  rx_kind_t kind;
  logic [3:0] bitc;
  logic [DATA_W-1:0] shreg, txreg, rd_data;
  logic [ADDR_W-1:0] ptr;
  logic rd_mode, mack, sda_oe;

  i2cee_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cee_wcycle #(.CYCLES(WRITE_CYCLES)) u_wcyc (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy)
  );

  i2cee_store u_store (
    .clk(clk), .rst_n(rst_n), .st_we(wr_ev), .st_addr(ptr), .st_data(shreg),
    .discard(discard), .commit(commit), .rd_addr(ptr), .rd_data(rd_data), .pending(pending)
  );

  // named internal events
  assign live    = !busy && !start_ev && !stop_ev;
  assign launch  = stop_ev && !busy && pending;
  assign commit  = launch && !wp_i;
  assign discard = (start_ev && !busy) || (launch && wp_i);
  assign ack_now = (kind != K_DEV) || dev_hit(shreg, dev_sel_i);
  assign wr_ev   = live && scl_fall && (st == S_ACKW) && (kind == K_WDAT);
  assign rd_ev   = live && scl_fall &&
                   (((st == S_ACK) && rd_mode) || ((st == S_MACK) && mack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_DEV; bitc <= '0; shreg <= '0; txreg <= '0;
      ptr <= '0; rd_mode <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
    end else if (busy) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (start_ev) begin
      st <= S_RX; kind <= K_DEV; bitc <= '0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      if (rd_ev) begin
        txreg  <= rd_data;
        sda_oe <= ~rd_data[DATA_W-1];
        bitc   <= 4'd1;
        ptr    <= lin_step(ptr);
        st     <= S_TX;
      end else begin
        unique case (st)
          S_RX: if (scl_rise) begin
            shreg <= {shreg[DATA_W-2:0], sda_s};
            bitc  <= bitc + 1'b1;
            if (bitc == 4'd7) st <= S_ACKW;
          end
          S_ACKW: if (scl_fall) begin
            unique case (kind)
              K_DEV:   begin rd_mode <= shreg[0]; kind <= K_WADR; end
              K_WADR:  begin ptr <= shreg;        kind <= K_WDAT; end
              default: ptr <= page_step(ptr);
            endcase
            if (ack_now) begin sda_oe <= 1'b1; st <= S_ACK; end
            else         st <= S_IGN;
          end
          S_ACK: if (scl_fall) begin
            sda_oe <= 1'b0; bitc <= '0; st <= S_RX;
          end
          S_TX: if (scl_fall) begin
            if (bitc == 4'd8) begin
              sda_oe <= 1'b0; st <= S_MACK;
            end else begin
              txreg  <= {txreg[DATA_W-2:0], 1'b0};
              sda_oe <= ~txreg[DATA_W-2];
              bitc   <= bitc + 1'b1;
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) st <= S_IGN;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = sda_oe;
endmodule

// File: rtl/i2cee_checks.sv
module i2cee_checks
  import i2cee_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              wr_ev,
  input logic              rd_ev,
  input logic [ADDR_W-1:0] ptr
);
  // R10: enable moves only after a detected bus event
  a_r10_oe_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

  // R7: silent while the write cycle runs
  a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R7: a write cycle only ever begins from a STOP
  a_r7_launch_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  // R3: write pointer keeps its page
  a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (ptr[ADDR_W-1:OFS_W] == $past(ptr[ADDR_W-1:OFS_W])) &&
              (ptr[OFS_W-1:0] == $past(ptr[OFS_W-1:0]) + 1'b1));

  // R4: read pointer steps by one across the array
  a_r4_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> ptr == $past(ptr) + 1'b1);
endmodule

bind i2c_eeprom_slave i2cee_checks u_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .wr_ev(wr_ev), .rd_ev(rd_ev), .ptr(ptr)
);

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
  localparam int WCYC = 400;
  localparam int QTR  = 8;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic dut_oe, sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~dut_oe;

  i2c_eeprom_slave #(.WRITE_CYCLES(WCYC)) i_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(dut_oe), .dev_sel_i(SEL), .wp_i(wp)
  );

  typedef struct { string req; int val; } item_t;
  item_t exp_q[$];
  int    act_q[$];
  int    n_chk = 0, n_fail = 0;

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (exp_q.size() != 0 && act_q.size() != 0) begin
      item_t e;
      int a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_chk++;
      if (a != e.val) begin
        n_fail++;
        $display("FAIL %s act=%0h exp=%0h", e.req, a, e.val);
      end
    end
  end

  function automatic logic [7:0] hdr(input logic [2:0] s, input logic rd);
    return {4'hA, s, rd};
  endfunction

  task automatic qwait(); repeat (QTR) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait(); m_sda = 1'b1; qwait(); qwait();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; qwait(); m_scl = 1'b1; qwait(); qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait(); b = sda_line; qwait(); m_scl = 1'b0; qwait();
  endtask

  // exp_ack: 0 = acknowledged, 1 = not
  task automatic send_byte(input logic [7:0] v, input string req, input int exp_ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    exp_q.push_back('{req, exp_ack});
    act_q.push_back(int'(b));
  endtask

  task automatic recv_byte(input logic [7:0] ev, input logic give_ack, input string req);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~give_ack);
    exp_q.push_back('{req, int'(ev)});
    act_q.push_back(int'(v));
  endtask

  task automatic poll(input int exp_ack, input string req);
    bus_start(); send_byte(hdr(SEL, 1'b0), req, exp_ack); bus_stop();
  endtask

  task automatic wr_one(input logic [7:0] a, input logic [7:0] d, input string req);
    bus_start();
    send_byte(hdr(SEL, 1'b0), req, 0);
    send_byte(a, req, 0);
    send_byte(d, req, 0);
    bus_stop();
    repeat (WCYC + 40) @(negedge clk);
  endtask

  task automatic rnd_read(input logic [7:0] a, input logic [7:0] ev, input string req);
    bus_start();
    send_byte(hdr(SEL, 1'b0), req, 0);
    send_byte(a, req, 0);
    bus_start();
    send_byte(hdr(SEL, 1'b1), req, 0);
    recv_byte(ev, 1'b0, req);
    bus_stop();
  endtask

  logic [7:0] pg [16];

  initial begin
    repeat (5) @(negedge clk);
    n_chk++;
    if (dut_oe !== 1'b0) begin
      n_fail++; $display("FAIL R10 reset act=%0b exp=0", dut_oe);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2 R7: byte write, poll during and after the cycle
    bus_start();
    send_byte(hdr(SEL, 1'b0), "R1 header", 0);
    send_byte(8'h05, "R2 word addr", 0);
    send_byte(8'hA5, "R2 data", 0);
    bus_stop();
    poll(1, "R7 busy poll");
    repeat (WCYC) @(negedge clk);
    poll(0, "R7 done poll");

    // R1 mismatching select and code
    bus_start(); send_byte(hdr(3'b100, 1'b0), "R1 sel mismatch", 1); bus_stop();
    bus_start(); send_byte({4'hB, SEL, 1'b1}, "R1 code mismatch", 1); bus_stop();

    // R5 random read
    rnd_read(8'h05, 8'hA5, "R5 random read");

    // R3 page write of 18 bytes from 1Eh, wraps in page 1
    for (int k = 0; k < 16; k++) pg[k] = 8'h00;
    bus_start();
    send_byte(hdr(SEL, 1'b0), "R3 header", 0);
    send_byte(8'h1E, "R3 addr", 0);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'h40 + 8'(k), "R2 page data", 0);
      pg[(14 + k) % 16] = 8'h40 + 8'(k);
    end
    bus_stop();
    repeat (WCYC + 40) @(negedge clk);
    // R5 current read: pointer is 10h after the wrap, R9 acks keep it going
    bus_start();
    send_byte(hdr(SEL, 1'b1), "R5 cur header", 0);
    for (int k = 0; k < 16; k++)
      recv_byte(pg[k], (k != 15), (k < 2 || k > 13) ? "R3 wrapped byte" : "R9 seq byte");
    bus_stop();

    // R4 rollover FFh -> 00h
    wr_one(8'h00, 8'h11, "R2 w00");
    wr_one(8'hFF, 8'h3C, "R2 wFF");
    bus_start();
    send_byte(hdr(SEL, 1'b0), "R4 hdr", 0);
    send_byte(8'hFF, "R4 addr", 0);
    bus_start();
    send_byte(hdr(SEL, 1'b1), "R4 rd hdr", 0);
    recv_byte(8'h3C, 1'b1, "R4 last byte");
    recv_byte(8'h11, 1'b0, "R4 rolled byte");
    bus_stop();

    // R8 protected write: acked, cycle runs, array unchanged
    wp = 1'b1;
    bus_start();
    send_byte(hdr(SEL, 1'b0), "R8 hdr", 0);
    send_byte(8'h05, "R8 addr", 0);
    send_byte(8'h00, "R8 data acked", 0);
    bus_stop();
    poll(1, "R8 cycle still runs");
    repeat (WCYC) @(negedge clk);
    wp = 1'b0;
    rnd_read(8'h05, 8'hA5, "R8 unchanged");

    // R6 repeated START discards staged data, no write cycle
    bus_start();
    send_byte(hdr(SEL, 1'b0), "R6 hdr", 0);
    send_byte(8'h05, "R6 addr", 0);
    send_byte(8'h77, "R6 data", 0);
    bus_start();
    bus_stop();
    poll(0, "R6 no cycle after abort");
    rnd_read(8'h05, 8'hA5, "R6 discarded");

    // R6 STOP after word address only
    bus_start();
    send_byte(hdr(SEL, 1'b0), "R6 hdr2", 0);
    send_byte(8'h40, "R6 addr2", 0);
    bus_stop();
    poll(0, "R6 no cycle addr only");

    repeat (8) @(negedge clk);
    if (exp_q.size() != act_q.size()) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard act=%0d exp=%0d", act_q.size(), exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule